// File: doc/BRIEF.md
# Receive Byte Queue with Fill Watermark and Idle Timeout

This block sits between a serial receiver's deserializer and the register interface of a UART. Each byte that the deserializer completes is pushed with a write strobe. Software, or a host state machine, pops bytes with a read strobe. The queue holds up to 64 bytes and returns them in arrival order.

Two flags tell software when it should service the queue. The level flag is high while the number of stored bytes is at or above a programmable watermark. The idle-timeout pulse fires when bytes have sat in the queue with no traffic for a programmable number of four-bit-period units. A bit-period tick input paces the timeout. A restart pulse starts the timeout over without touching the stored bytes. A soft-clear pulse empties the queue and clears every flag. A write into a full queue is dropped and latches a sticky overrun flag.

Top module: `rx_byte_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `empty`=1, `full`=0, `level_hit`=0, `idle_timeout`=0, `overrun`=0 and `rd_byte`=0.
- R2: Bytes leave in the order they were accepted. A read strobe on a non-empty queue loads the oldest byte into `rd_byte` at that clock edge. Between reads, `rd_byte` holds its value.
- R3: `empty` is high exactly when no byte is stored, and it goes low at the edge that accepts the first byte. `full` goes high at the edge that accepts the 64th stored byte.
- R4: A read strobe on an empty queue loads 0 into `rd_byte` and does not move the read position. The next byte written is the next byte read.
- R5: A write strobe while `full` is high drops the byte, even if a read happens in the same cycle. The dropped byte never appears at `rd_byte`. It sets `overrun`, which stays high until a soft clear.
- R6: `level_hit` is high while the stored count is greater than or equal to `watermark` (6 bits). A `watermark` of 0 keeps `level_hit` low.
- R7: With `idle_limit`=L (1..255), `idle_timeout` is a one-cycle pulse. It is high in the cycle after the edge that counts the 4·L-th `bit_tick` since the last reload. After firing, the block gives no further pulse until the next reload.
- R8: An `idle_limit` of 0 disables the timeout, so `idle_timeout` stays low.
- R9: Four events reload the timeout count to zero: any write strobe, a read of a stored byte, a `restart_tmo` pulse, and a soft clear. `restart_tmo` leaves the stored bytes unchanged.
- R10: Ticks are not counted while the queue is empty, so `idle_timeout` never rises while `empty` is high.
- R11: A `soft_clear` pulse wins over a write or read strobe in the same cycle. At that edge the queue empties, `overrun` clears and `rd_byte` becomes 0.
- R12: A read and a write in the same cycle on a queue that is neither empty nor full return the oldest byte and store the new one. The count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_byte | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from the register side |
| rd_byte | output | 8 | Last popped byte (0 after an empty pop) |
| watermark | input | 6 | Fill threshold for `level_hit` |
| idle_limit | input | 8 | Timeout length in four-bit-period units, 0 disables |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| restart_tmo | input | 1 | Pulse that restarts the idle timeout |
| soft_clear | input | 1 | Pulse that empties the queue and clears flags |
| empty | output | 1 | No byte stored |
| full | output | 1 | 64 bytes stored |
| level_hit | output | 1 | Stored count at or above watermark |
| idle_timeout | output | 1 | One-cycle idle timeout event |
| overrun | output | 1 | Sticky: a byte was dropped while full |

## Verification
The properties assume the strobes `wr_en`, `rd_en`, `restart_tmo`, `soft_clear` and `bit_tick` are sampled as clean single-cycle levels. They also assume that `idle_limit` is stable across the edge that follows a check: the disabled-timeout property relates the limit in one cycle to the pulse in the next. The stimulus drives every input on the falling edge, sets `idle_limit` and `watermark` only while no ticks are running, and gives each tick as an isolated one-cycle pulse. The full-queue scenarios push exactly to the 64-byte boundary and then drain completely, so each scenario starts from an empty queue.

// File: rtl/rxq_pkg.sv
// Package: shared defaults and types for the receive byte queue.
// Assumes: nothing; holds only constants and type definitions.
package rxq_pkg;

    localparam int RXQ_DEPTH      = 64;
    localparam int RXQ_DATA_W     = 8;
    localparam int RXQ_LIMIT_W    = 8;
    localparam int RXQ_UNIT_TICKS = 4;

    // Strobe decode result, one flag per queue action in a cycle.
    typedef struct packed {
        logic flush;   // soft clear, overrides everything else
        logic push;    // byte accepted into storage
        logic drop;    // byte refused because storage is full
        logic pop;     // oldest byte removed
        logic rd_req;  // read strobe seen (loads rd_byte)
        logic reload;  // idle timer starts over
    } rxq_evt_t;

    // Idle timer state: counting allowed, or already fired.
    typedef enum logic {
        TMR_ARMED = 1'b0,
        TMR_SPENT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/rxq_ctrl.sv
// Module: rxq_ctrl
// Decodes the raw strobes into queue actions for this cycle.
// Assumes: empty/full reflect the registered stored count of this cycle.
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic wr_en,
    input  logic rd_en,
    input  logic restart_tmo,
    input  logic soft_clear,
    input  logic empty,
    input  logic full,
    output logic do_flush,
    output logic do_push,
    output logic do_drop,
    output logic do_pop,
    output logic do_rd_req,
    output logic do_reload
);

    rxq_evt_t evt;

    // Purpose: build the action set; soft clear masks all other actions.
    always_comb begin
        evt        = '0;
        evt.flush  = soft_clear;
        evt.push   = wr_en && !full  && !soft_clear;
        evt.drop   = wr_en &&  full  && !soft_clear;
        evt.pop    = rd_en && !empty && !soft_clear;
        evt.rd_req = rd_en && !soft_clear;
        evt.reload = soft_clear || restart_tmo || wr_en || evt.pop;
    end

    assign do_flush  = evt.flush;
    assign do_push   = evt.push;
    assign do_drop   = evt.drop;
    assign do_pop    = evt.pop;
    assign do_rd_req = evt.rd_req;
    assign do_reload = evt.reload;

endmodule

// File: rtl/rxq_store.sv
// Module: rxq_store
// Circular byte storage with read/write positions, stored count and
// the registered read-data output.
// Assumes: push is never asserted while the count equals DEPTH and pop
// never while it is zero (rxq_ctrl guarantees this).
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       rd_req,
    input  logic [DATA_W-1:0]          wr_byte,
    output logic [DATA_W-1:0]          rd_byte,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_pos;
    logic [AW-1:0]     rd_pos;

    // Purpose: store an accepted byte at the write position.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_pos] <= wr_byte;
        end
    end

    // Purpose: advance the write position with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_pos <= '0;
        end else if (push) begin
            wr_pos <= (wr_pos == LAST) ? '0 : wr_pos + 1'b1;
        end
    end

    // Purpose: advance the read position with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_pos <= '0;
        end else if (pop) begin
            rd_pos <= (rd_pos == LAST) ? '0 : rd_pos + 1'b1;
        end
    end

    // Purpose: track how many bytes are held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Purpose: load read data on a read strobe, zero when nothing is held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_byte <= '0;
        end else if (rd_req) begin
            rd_byte <= pop ? mem[rd_pos] : '0;
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Module: rxq_flags
// Derives empty/full/level flags from the stored count and keeps the
// sticky overrun flag.
// Assumes: count is the registered count from rxq_store.
module rxq_flags #(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       drop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [$clog2(DEPTH)-1:0]   watermark,
    output logic                       empty,
    output logic                       full,
    output logic                       level_hit,
    output logic                       overrun
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int WW = $clog2(DEPTH);

    logic [CW-1:0] wm_ext;

    // Purpose: occupancy flags straight from the count.
    always_comb begin
        wm_ext    = CW'(watermark);
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        level_hit = (watermark != WW'(0)) && (count >= wm_ext);
    end

    // Purpose: latch a dropped write until soft clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_idle_timer.sv
// Module: rxq_idle_timer
// Counts bit-period ticks in groups of UNIT_TICKS while data is held and
// emits a one-cycle pulse when the unit count reaches the limit.
// Assumes: bit_tick is a single-cycle pulse; limit 0 means disabled.
module rxq_idle_timer
    import rxq_pkg::*;
#(
    parameter int LIMIT_W    = 8,
    parameter int UNIT_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload,
    input  logic               holding,
    input  logic               bit_tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               tmo_pulse
);

    tmr_state_e       state;
    logic [LIMIT_W-1:0] units;
    logic [LIMIT_W:0]   units_nx;
    logic               count_en;
    logic               unit_done;

    // Purpose: counting is allowed only when armed, enabled and holding data.
    always_comb begin
        count_en = (state == TMR_ARMED) && (limit != '0) && holding;
        units_nx = {1'b0, units} + 1'b1;
    end

    generate
        if (UNIT_TICKS > 1) begin : g_prescale
            localparam int PW = $clog2(UNIT_TICKS);
            localparam logic [PW-1:0] PLAST = PW'(UNIT_TICKS - 1);
            logic [PW-1:0] pre;

            // Purpose: divide the bit tick down to one unit.
            always_ff @(posedge clk) begin
                if (!rst_n || reload) begin
                    pre <= '0;
                end else if (count_en && bit_tick) begin
                    pre <= (pre == PLAST) ? '0 : pre + 1'b1;
                end
            end

            assign unit_done = bit_tick && (pre == PLAST);
        end else begin : g_direct
            assign unit_done = bit_tick;
        end
    endgenerate

    // Purpose: accumulate units and fire once when the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TMR_ARMED;
            units     <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= 1'b0;
            if (reload) begin
                state <= TMR_ARMED;
                units <= '0;
            end else if (count_en && unit_done) begin
                if (units_nx >= {1'b0, limit}) begin
                    state     <= TMR_SPENT;
                    tmo_pulse <= 1'b1;
                    units     <= '0;
                end else begin
                    units <= units_nx[LIMIT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/rx_byte_queue.sv
// Module: rx_byte_queue (top)
// Receive byte queue with watermark flag, idle timeout and overrun flag.
// Assumes: DEPTH >= 2; strobes are synchronous to clk.
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH      = RXQ_DEPTH,
    parameter int DATA_W     = RXQ_DATA_W,
    parameter int LIMIT_W    = RXQ_LIMIT_W,
    parameter int UNIT_TICKS = RXQ_UNIT_TICKS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_byte,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_byte,
    input  logic [$clog2(DEPTH)-1:0] watermark,
    input  logic [LIMIT_W-1:0]       idle_limit,
    input  logic                     bit_tick,
    input  logic                     restart_tmo,
    input  logic                     soft_clear,
    output logic                     empty,
    output logic                     full,
    output logic                     level_hit,
    output logic                     idle_timeout,
    output logic                     overrun
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          flush_s;
    logic          push_s;
    logic          drop_s;
    logic          pop_s;
    logic          rd_req_s;
    logic          reload_s;
    logic [CW-1:0] count_s;

    rxq_ctrl u_ctrl (
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .restart_tmo (restart_tmo),
        .soft_clear  (soft_clear),
        .empty       (empty),
        .full        (full),
        .do_flush    (flush_s),
        .do_push     (push_s),
        .do_drop     (drop_s),
        .do_pop      (pop_s),
        .do_rd_req   (rd_req_s),
        .do_reload   (reload_s)
    );

    rxq_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_s),
        .push    (push_s),
        .pop     (pop_s),
        .rd_req  (rd_req_s),
        .wr_byte (wr_byte),
        .rd_byte (rd_byte),
        .count   (count_s)
    );

    rxq_flags #(
        .DEPTH (DEPTH)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_s),
        .drop      (drop_s),
        .count     (count_s),
        .watermark (watermark),
        .empty     (empty),
        .full      (full),
        .level_hit (level_hit),
        .overrun   (overrun)
    );

    rxq_idle_timer #(
        .LIMIT_W    (LIMIT_W),
        .UNIT_TICKS (UNIT_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload_s),
        .holding   (!empty),
        .bit_tick  (bit_tick),
        .limit     (idle_limit),
        .tmo_pulse (idle_timeout)
    );

endmodule

// File: rtl/rxq_checker.sv
// Module: rxq_checker
// Port-level properties of rx_byte_queue, attached by bind below.
// Assumes: inputs change only between clock edges.
module rxq_checker #(
    parameter int DEPTH   = 64,
    parameter int DATA_W  = 8,
    parameter int LIMIT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [DATA_W-1:0]        rd_byte,
    input logic [$clog2(DEPTH)-1:0] watermark,
    input logic [LIMIT_W-1:0]       idle_limit,
    input logic                     soft_clear,
    input logic                     empty,
    input logic                     full,
    input logic                     level_hit,
    input logic                     idle_timeout,
    input logic                     overrun
);

    // R3: the queue can never be both empty and full.
    p_excl_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R4: a read of an empty queue yields zero.
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !soft_clear) |=> (rd_byte == '0));

    // R5: overrun only rises from a write into a full queue.
    p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && !(wr_en && full)) |=> !overrun);

    // R5: overrun is sticky until a soft clear.
    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !soft_clear) |=> overrun);

    // R5: a write with no read cannot take the queue out of full.
    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !soft_clear) |=> full);

    // R6: watermark zero keeps the level flag low.
    p_wm_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (watermark == '0) |-> !level_hit);

    // R7: the timeout event lasts one cycle.
    p_tmo_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_timeout |=> !idle_timeout);

    // R8: a zero limit suppresses the timeout.
    p_tmo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_limit == '0) |=> !idle_timeout);

    // R10: no timeout event follows a cycle with an empty queue.
    p_tmo_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !idle_timeout);

    // R11: soft clear leaves an empty, clean queue.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clear |=> (empty && !overrun && !idle_timeout && rd_byte == '0));

endmodule

bind rx_byte_queue rxq_checker #(
    .DEPTH   (DEPTH),
    .DATA_W  (DATA_W),
    .LIMIT_W (LIMIT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_byte      (rd_byte),
    .watermark    (watermark),
    .idle_limit   (idle_limit),
    .soft_clear   (soft_clear),
    .empty        (empty),
    .full         (full),
    .level_hit    (level_hit),
    .idle_timeout (idle_timeout),
    .overrun      (overrun)
);

// File: tb/sim_rx_byte_queue.sv
// Directed bench for rx_byte_queue: one task per scenario.
module sim_rx_byte_queue;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_byte;
    logic [5:0] watermark = 6'd0;
    logic [7:0] idle_limit = 8'd0;
    logic       bit_tick = 1'b0;
    logic       restart_tmo = 1'b0;
    logic       soft_clear = 1'b0;
    logic       empty, full, level_hit, idle_timeout, overrun;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_byte_queue u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_byte      (wr_byte),
        .rd_en        (rd_en),
        .rd_byte      (rd_byte),
        .watermark    (watermark),
        .idle_limit   (idle_limit),
        .bit_tick     (bit_tick),
        .restart_tmo  (restart_tmo),
        .soft_clear   (soft_clear),
        .empty        (empty),
        .full         (full),
        .level_hit    (level_hit),
        .idle_timeout (idle_timeout),
        .overrun      (overrun)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_byte = b;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string tag);
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk(rd_byte, exp, tag);
    endtask

    // One isolated tick; checks the pulse after it and its absence one cycle later.
    task automatic tick_chk(input logic exp, input string tag);
        bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
        chk(idle_timeout, exp, tag);
        cyc();
        chk(idle_timeout, 1'b0, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        chk(empty, 1, "R1 empty");
        chk(full, 0, "R1 full");
        chk(level_hit, 0, "R1 level");
        chk(idle_timeout, 0, "R1 timeout");
        chk(overrun, 0, "R1 overrun");
        chk(rd_byte, 0, "R1 rd_byte");
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic t_order();
        push(8'h11);
        chk(empty, 0, "R3 empty low after first write");
        push(8'h22); push(8'h33); push(8'h44); push(8'h55);
        pop_chk(8'h11, "R2 order 0");
        cyc();
        chk(rd_byte, 8'h11, "R2 hold");
        pop_chk(8'h22, "R2 order 1");
        pop_chk(8'h33, "R2 order 2");
        pop_chk(8'h44, "R2 order 3");
        pop_chk(8'h55, "R2 order 4");
        chk(empty, 1, "R3 empty after drain");
    endtask

    task automatic t_empty_read();
        pop_chk(8'h00, "R4 empty read zero");
        pop_chk(8'h00, "R4 second empty read");
        push(8'hA7);
        pop_chk(8'hA7, "R4 position unchanged");
        chk(empty, 1, "R4 empty again");
    endtask

    task automatic t_fill_overrun();
        for (int i = 0; i < 64; i++) begin
            push(8'(i + 1));
            if (i == 62) chk(full, 0, "R3 not full at 63");
        end
        chk(full, 1, "R3 full at 64");
        chk(overrun, 0, "R5 no overrun yet");
        push(8'hEE);
        chk(overrun, 1, "R5 overrun set");
        chk(full, 1, "R5 still full");
        wr_en = 1'b1; wr_byte = 8'hDD; rd_en = 1'b1;
        cyc();
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_byte, 8'h01, "R5 read during full write");
        chk(full, 0, "R5 dropped write not stored");
        for (int i = 1; i < 64; i++) pop_chk(8'(i + 1), "R5 contents intact");
        chk(empty, 1, "R5 drained");
        chk(overrun, 1, "R5 overrun sticky");
        soft_clear = 1'b1; cyc(); soft_clear = 1'b0;
        chk(overrun, 0, "R11 overrun cleared");
    endtask

    task automatic t_watermark();
        watermark = 6'd3;
        push(8'h01); push(8'h02);
        chk(level_hit, 0, "R6 below watermark");
        push(8'h03);
        chk(level_hit, 1, "R6 at watermark");
        push(8'h04);
        chk(level_hit, 1, "R6 above watermark");
        watermark = 6'd0;
        cyc();
        chk(level_hit, 0, "R6 watermark zero");
        watermark = 6'd4;
        pop_chk(8'h01, "R6 pop");
        chk(level_hit, 0, "R6 drop below");
        pop_chk(8'h02, "R6 pop"); pop_chk(8'h03, "R6 pop"); pop_chk(8'h04, "R6 pop");
        watermark = 6'd0;
    endtask

    task automatic t_timeout();
        idle_limit = 8'd2;
        push(8'h5A);
        for (int i = 1; i < 8; i++) tick_chk(1'b0, "R7 before limit");
        tick_chk(1'b1, "R7 fires at 4*L ticks");
        for (int i = 0; i < 8; i++) tick_chk(1'b0, "R7 spent until reload");
        pop_chk(8'h5A, "R7 data");
    endtask

    task automatic t_restart();
        idle_limit = 8'd2;
        push(8'h6B);
        for (int i = 0; i < 5; i++) tick_chk(1'b0, "R9 pre-restart");
        restart_tmo = 1'b1; cyc(); restart_tmo = 1'b0;
        for (int i = 1; i < 8; i++) tick_chk(1'b0, "R9 restart reloads");
        tick_chk(1'b1, "R9 fire after restart");
        push(8'h7C);
        for (int i = 0; i < 5; i++) tick_chk(1'b0, "R9 after write");
        pop_chk(8'h6B, "R9 restart kept data");
        for (int i = 1; i < 8; i++) tick_chk(1'b0, "R9 read reloads");
        tick_chk(1'b1, "R9 fire after read");
        pop_chk(8'h7C, "R9 data");
    endtask

    task automatic t_disabled();
        idle_limit = 8'd0;
        push(8'h42);
        for (int i = 0; i < 40; i++) tick_chk(1'b0, "R8 disabled");
        pop_chk(8'h42, "R8 data");
    endtask

    task automatic t_empty_noticks();
        idle_limit = 8'd1;
        for (int i = 0; i < 12; i++) tick_chk(1'b0, "R10 empty no count");
        push(8'h99);
        for (int i = 1; i < 4; i++) tick_chk(1'b0, "R10 counting");
        tick_chk(1'b1, "R10 fires once holding");
        pop_chk(8'h99, "R10 data");
        idle_limit = 8'd0;
    endtask

    task automatic t_clear_priority();
        push(8'h0A); push(8'h0B); push(8'h0C);
        pop_chk(8'h0A, "R11 setup");
        soft_clear = 1'b1; wr_en = 1'b1; wr_byte = 8'hFF; rd_en = 1'b1;
        cyc();
        soft_clear = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk(empty, 1, "R11 empty after clear");
        chk(rd_byte, 0, "R11 rd_byte zero");
        pop_chk(8'h00, "R11 write ignored");
    endtask

    task automatic t_simul();
        push(8'hC1); push(8'hC2);
        wr_en = 1'b1; wr_byte = 8'hC3; rd_en = 1'b1;
        cyc();
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_byte, 8'hC1, "R12 read during write");
        pop_chk(8'hC2, "R12 order");
        pop_chk(8'hC3, "R12 new byte stored");
        chk(empty, 1, "R12 count kept");
    endtask

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_fill_overrun();
        t_watermark();
        t_timeout();
        t_restart();
        t_disabled();
        t_empty_noticks();
        t_clear_priority();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule